// File: doc/BRIEF.md
# Indexed Configuration Port Controller

This block sits behind a byte-wide host I/O decode and gives software a two-address window into a configuration space. The lower address (port select 0) takes index bytes. The upper address (port select 1) carries the data for the register that the last index named. The space stays locked until software writes the enter key to the index port twice in a row. A single exit key written to the index port locks it again.

Once the space is open, a handful of global registers answer directly. These are a device-number select and read-only identity bytes. Every index from 0x30 upward is passed on to one bank of per-device registers, picked by the device-number select. The pass-through is a one-cycle write or read strobe together with the index, the write data and the current device number. Read data comes back from the bank in the same cycle.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked, the index is 0x00 and the device-number select (`ld_sel_o`) is 0x00.
- R2: Two consecutive index-port writes of 0x87 open the space on the clock edge of the second one. Data-port accesses in between do not break the sequence.
- R3: While locked, an index-port write of any byte other than 0x87 restarts the key sequence. This applies also after a first 0x87, so 0x87, 0x55, 0x87 leaves the port locked with one key counted.
- R4: While open, an index-port write of 0xAA locks the space and leaves the stored index unchanged. Any other index-port byte, 0x87 included, becomes the new index.
- R5: While locked, reads of either port return 0xFF and data-port writes have no effect: no device strobe, no change to the device select, no change to the index.
- R6: While open, a read of the index port returns the current index.
- R7: While open, a data write at index 0x07 loads the device-number select, which drives `ld_sel_o` from the next cycle. A data read at 0x07 returns it.
- R8: While open, data reads return identity bytes: 0x20 gives DEV_ID[15:8], 0x21 gives DEV_ID[7:0], 0x22 gives DEV_REV, 0x23 gives MFR_ID[15:8] (default 0x19) and 0x24 gives MFR_ID[7:0] (default 0x34). Any other index below 0x30 reads 0x00. Data writes to global indices other than 0x07 have no effect.
- R9: While open with index at or above 0x30, a data write pulses `ld_wr_o` for that cycle and a data read pulses `ld_rd_o`. A read that coincides with a write is dropped. `ld_idx_o` carries the index, `ld_wdata_o` the write byte, and the data-port read returns `ld_rdata_i`.
- R10: Asserting the asynchronous reset in the middle of an open session relocks the port and clears the device select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 1 | Port select: 0 index port, 1 data port |
| io_wr_i | input | 1 | Host write strobe, one cycle per byte |
| io_rd_i | input | 1 | Host read strobe, one cycle per byte |
| io_wdata_i | input | 8 | Host write byte |
| io_rdata_o | output | 8 | Host read byte for the addressed port (combinational) |
| ld_sel_o | output | 8 | Current device-number select |
| ld_idx_o | output | 8 | Register index passed to the device bank |
| ld_wdata_o | output | 8 | Write byte passed to the device bank |
| ld_wr_o | output | 1 | Device bank write strobe |
| ld_rd_o | output | 1 | Device bank read strobe |
| ld_rdata_i | input | 8 | Read byte returned by the selected device bank |

## Verification
The key logic is driven with a clean double key, a key split by a data write, a key broken by a foreign byte, and a foreign byte followed by two keys. Together these separate a correct "consecutive index writes" rule from a simple key counter and from a detector that never restarts. Locked data writes are followed by an unlock and a read-back of the device select. This shows they were really dropped and not just hidden behind 0xFF. Accesses on both sides of the 0x30 boundary, along with a combined read and write, separate global decode from pass-through and check the strobe exclusion.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int unsigned DW = 8;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_KEY1   = 2'd1,
    ST_OPEN   = 2'd2
  } key_state_e;

  localparam logic [DW-1:0] KEY_ENTER    = 8'h87;
  localparam logic [DW-1:0] KEY_EXIT     = 8'hAA;
  localparam logic [DW-1:0] IDX_LDSEL    = 8'h07;
  localparam logic [DW-1:0] IDX_DEVID_HI = 8'h20;
  localparam logic [DW-1:0] IDX_DEVID_LO = 8'h21;
  localparam logic [DW-1:0] IDX_DEVREV   = 8'h22;
  localparam logic [DW-1:0] IDX_MFR_HI   = 8'h23;
  localparam logic [DW-1:0] IDX_MFR_LO   = 8'h24;
  localparam logic [DW-1:0] IDX_LD_BASE  = 8'h30;
  localparam logic [DW-1:0] RD_LOCKED    = 8'hFF;
endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idx_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          open_o,
  output logic [DW-1:0] idx_o
);
  key_state_e state_q;
  logic [DW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOCKED;
      idx_q   <= '0;
    end else if (idx_wr_i) begin
      unique case (state_q)
        ST_LOCKED: state_q <= (wdata_i == KEY_ENTER) ? ST_KEY1 : ST_LOCKED;
        ST_KEY1:   state_q <= (wdata_i == KEY_ENTER) ? ST_OPEN : ST_LOCKED;
        ST_OPEN: begin
          if (wdata_i == KEY_EXIT) state_q <= ST_LOCKED;
          else                     idx_q   <= wdata_i;
        end
        default:   state_q <= ST_LOCKED;
      endcase
    end
  end

  assign open_o = (state_q == ST_OPEN);
  assign idx_o  = idx_q;

  AST_ENTRY_NEEDS_TWO_KEYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(idx_wr_i && wdata_i == KEY_ENTER && state_q == ST_KEY1)); // R2
  AST_EXIT_RELOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && idx_wr_i && wdata_i == KEY_EXIT) |=> (!open_o && $stable(idx_o))); // R4
  AST_IDX_FROZEN_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_o |=> $stable(idx_o)); // R5
endmodule

// File: rtl/sio_global_regs.sv
module sio_global_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0]   DEV_ID  = 16'h0A5C,
  parameter logic [DW-1:0] DEV_REV = 8'h11,
  parameter logic [15:0]   MFR_ID  = 16'h1934
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          open_i,
  input  logic          data_wr_i,
  input  logic [DW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ldn_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] ldn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       ldn_q <= '0;
    else if (open_i && data_wr_i && idx_i == IDX_LDSEL) ldn_q <= wdata_i;
  end

  always_comb begin
    unique case (idx_i)
      IDX_LDSEL:    rdata_o = ldn_q;
      IDX_DEVID_HI: rdata_o = DEV_ID[15:8];
      IDX_DEVID_LO: rdata_o = DEV_ID[7:0];
      IDX_DEVREV:   rdata_o = DEV_REV;
      IDX_MFR_HI:   rdata_o = MFR_ID[15:8];
      IDX_MFR_LO:   rdata_o = MFR_ID[7:0];
      default:      rdata_o = '0;
    endcase
  end

  assign ldn_o = ldn_q;

  AST_LDN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(open_i && data_wr_i && idx_i == IDX_LDSEL) |=> $stable(ldn_o)); // R7
endmodule

// File: rtl/sio_ld_router.sv
module sio_ld_router
  import sio_cfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          open_i,
  input  logic          data_wr_i,
  input  logic          data_rd_i,
  input  logic [DW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] glb_rdata_i,
  input  logic [DW-1:0] ld_rdata_i,
  output logic          ld_wr_o,
  output logic          ld_rd_o,
  output logic [DW-1:0] ld_idx_o,
  output logic [DW-1:0] ld_wdata_o,
  output logic [DW-1:0] rdata_o
);
  logic to_ld;

  assign to_ld      = (idx_i >= IDX_LD_BASE);
  assign ld_wr_o    = open_i && to_ld && data_wr_i;
  assign ld_rd_o    = open_i && to_ld && data_rd_i && !data_wr_i;
  assign ld_idx_o   = idx_i;
  assign ld_wdata_o = wdata_i;
  assign rdata_o    = to_ld ? ld_rdata_i : glb_rdata_i;

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ld_wr_o, ld_rd_o})); // R9
  AST_NO_STROBE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_i |-> (!ld_wr_o && !ld_rd_o)); // R5
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] DEV_ID  = 16'h0A5C,
  parameter logic [7:0]  DEV_REV = 8'h11,
  parameter logic [15:0] MFR_ID  = 16'h1934
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       io_addr_i,
  input  logic       io_wr_i,
  input  logic       io_rd_i,
  input  logic [7:0] io_wdata_i,
  output logic [7:0] io_rdata_o,
  output logic [7:0] ld_sel_o,
  output logic [7:0] ld_idx_o,
  output logic [7:0] ld_wdata_o,
  output logic       ld_wr_o,
  output logic       ld_rd_o,
  input  logic [7:0] ld_rdata_i
);
  logic          idx_wr, data_wr, data_rd, open;
  logic [DW-1:0] idx, glb_rdata, data_rdata;

  assign idx_wr  = io_wr_i && !io_addr_i;
  assign data_wr = io_wr_i && io_addr_i;
  assign data_rd = io_rd_i && io_addr_i;

  sio_key_fsm u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_wr_i (idx_wr),
    .wdata_i  (io_wdata_i),
    .open_o   (open),
    .idx_o    (idx)
  );

  sio_global_regs #(
    .DEV_ID  (DEV_ID),
    .DEV_REV (DEV_REV),
    .MFR_ID  (MFR_ID)
  ) u_glb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .open_i    (open),
    .data_wr_i (data_wr),
    .idx_i     (idx),
    .wdata_i   (io_wdata_i),
    .ldn_o     (ld_sel_o),
    .rdata_o   (glb_rdata)
  );

  sio_ld_router u_route (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .open_i      (open),
    .data_wr_i   (data_wr),
    .data_rd_i   (data_rd),
    .idx_i       (idx),
    .wdata_i     (io_wdata_i),
    .glb_rdata_i (glb_rdata),
    .ld_rdata_i  (ld_rdata_i),
    .ld_wr_o     (ld_wr_o),
    .ld_rd_o     (ld_rd_o),
    .ld_idx_o    (ld_idx_o),
    .ld_wdata_o  (ld_wdata_o),
    .rdata_o     (data_rdata)
  );

  assign io_rdata_o = !open     ? RD_LOCKED :
                      io_addr_i ? data_rdata : idx;

  AST_EXIT_READS_FF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && !io_addr_i && io_wdata_i == KEY_EXIT) |=> (io_rdata_o == RD_LOCKED)); // R4
  AST_LOCKED_WR_NO_LDN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open && data_wr) |=> $stable(ld_sel_o)); // R5
endmodule

// File: tb/sio_cfg_port_test.sv
`timescale 1ns/100ps
module sio_cfg_port_test;
  localparam logic [15:0] T_DEV_ID  = 16'h0A5C;
  localparam logic [7:0]  T_DEV_REV = 8'h11;
  localparam logic [15:0] T_MFR_ID  = 16'h1934;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_addr = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0, ld_rdata = '0;
  logic [7:0] io_rdata, ld_sel, ld_idx, ld_wdata;
  logic       ld_wr, ld_rd;

  int vectors = 0, errors = 0;

  // reference model state
  bit       m_open = 0, m_key = 0;
  bit [7:0] m_idx = 0, m_ldn = 0;

  always #2 clk = ~clk;

  sio_cfg_port #(.DEV_ID(T_DEV_ID), .DEV_REV(T_DEV_REV), .MFR_ID(T_MFR_ID)) uut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(io_addr), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata), .ld_sel_o(ld_sel), .ld_idx_o(ld_idx),
    .ld_wdata_o(ld_wdata), .ld_wr_o(ld_wr), .ld_rd_o(ld_rd), .ld_rdata_i(ld_rdata)
  );

  function automatic bit [7:0] exp_data_read();
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return T_DEV_ID[15:8];
      8'h21: return T_DEV_ID[7:0];
      8'h22: return T_DEV_REV;
      8'h23: return T_MFR_ID[15:8];
      8'h24: return T_MFR_ID[7:0];
      default: return (m_idx >= 8'h30) ? ld_rdata : 8'h00;
    endcase
  endfunction

  task automatic step(input bit wr, input bit rd, input bit a, input bit [7:0] d,
                      input bit [7:0] ldr, input string req);
    bit [7:0] e_rd, e_sel;
    bit e_wr, e_rs, bad;
    @(negedge clk);
    io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d; ld_rdata = ldr;
    #1;
    e_rd  = !m_open ? 8'hFF : (a ? exp_data_read() : m_idx);
    e_wr  = m_open && wr && a && (m_idx >= 8'h30);
    e_rs  = m_open && rd && !wr && a && (m_idx >= 8'h30);
    e_sel = m_ldn;
    bad = (io_rdata !== e_rd) || (ld_wr !== e_wr) || (ld_rd !== e_rs) || (ld_sel !== e_sel);
    if ((e_wr || e_rs) && (ld_idx !== m_idx || ld_wdata !== d)) bad = 1;
    vectors++;
    if (bad) begin
      errors++;
      $display("FAIL %s: rdata=%h/%h wr=%b/%b rd=%b/%b sel=%h/%h idx=%h/%h wdata=%h/%h (act/exp)",
               req, io_rdata, e_rd, ld_wr, e_wr, ld_rd, e_rs, ld_sel, e_sel,
               ld_idx, m_idx, ld_wdata, d);
    end
    // model update at the coming edge
    if (wr && !a) begin
      if (m_open) begin
        if (d == 8'hAA) begin m_open = 0; m_key = 0; end
        else m_idx = d;
      end else if (m_key) begin
        m_open = (d == 8'h87); m_key = 0;
      end else m_key = (d == 8'h87);
    end else if (wr && a && m_open && m_idx == 8'h07) m_ldn = d;
  endtask

  task automatic idle(input string req);
    step(0, 0, 0, 8'h00, 8'h00, req);
  endtask
  task automatic iw(input bit [7:0] d, input string req);
    step(1, 0, 0, d, 8'h00, req);
  endtask
  task automatic dw(input bit [7:0] d, input string req);
    step(1, 0, 1, d, 8'h00, req);
  endtask
  task automatic dr(input bit [7:0] ldr, input string req);
    step(0, 1, 1, 8'h00, ldr, req);
  endtask
  task automatic ir(input string req);
    step(0, 1, 0, 8'h00, 8'h00, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    io_wr = 0; io_rd = 0;
    #1;
    m_open = 0; m_key = 0; m_idx = 0; m_ldn = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete (act=hung exp=done)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    ir("R1"); dr(8'h3C, "R1"); idle("R1");
    // R5 locked writes dropped
    iw(8'h07, "R5"); dw(8'h05, "R5"); dr(8'h99, "R5");
    iw(8'h31, "R5"); dw(8'h44, "R5");
    // R3 broken sequences
    iw(8'h87, "R3"); iw(8'h55, "R3"); iw(8'h87, "R3"); ir("R3");
    // R2 completes with key already counted
    iw(8'h87, "R2"); ir("R2");
    // R5 index not changed by locked writes; LDN still 0
    iw(8'h07, "R6"); ir("R6"); dr(8'h00, "R7");
    // R7 load device select
    dw(8'h07, "R7"); dr(8'h00, "R7"); idle("R7");
    // R8 identity bytes and unused globals
    iw(8'h20, "R8"); dr(8'h00, "R8");
    iw(8'h21, "R8"); dr(8'h00, "R8");
    iw(8'h22, "R8"); dr(8'h00, "R8");
    iw(8'h23, "R8"); dr(8'h00, "R8");
    iw(8'h24, "R8"); dr(8'h00, "R8");
    iw(8'h20, "R8"); dw(8'h00, "R8"); dr(8'h00, "R8");
    iw(8'h10, "R8"); dw(8'h77, "R8"); dr(8'h00, "R8");
    iw(8'h2F, "R8"); dr(8'hEE, "R8");
    // R9 device bank pass-through
    iw(8'h30, "R9"); dw(8'h01, "R9"); dr(8'h5E, "R9");
    iw(8'h61, "R9"); dw(8'hC8, "R9"); dr(8'hA1, "R9");
    step(1, 1, 1, 8'h3D, 8'h12, "R9");
    iw(8'h87, "R4"); ir("R4"); iw(8'h61, "R4");
    // R4 exit keeps index
    iw(8'hAA, "R4"); ir("R4"); dr(8'h42, "R5"); dw(8'h09, "R5");
    // R2 data access between keys does not break sequence
    iw(8'h87, "R2"); dw(8'h11, "R2"); dr(8'h00, "R2"); iw(8'h87, "R2");
    ir("R4"); dr(8'h6B, "R9");
    iw(8'h07, "R7"); dr(8'h00, "R7");
    // R10 reset mid-session
    do_reset();
    ir("R10"); dr(8'h00, "R10"); idle("R10");
    iw(8'h87, "R10"); iw(8'h87, "R10"); iw(8'h07, "R10"); dr(8'h00, "R10");
    idle("R10");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule